// File: doc/BRIEF.md
# Tournament Branch Direction Chooser

This block predicts whether a conditional branch will be taken by running two small component predictors side by side and letting a per-branch selector decide which one to trust. The first component is a table of 2-bit saturating counters indexed by low bits of the branch address (bimodal). The second is a correlating predictor. Its counter table is indexed by the recent global outcome history joined with a few low address bits. A third table of 2-bit counters, also indexed by low address bits, holds the selector. Its most significant bit names the component whose prediction is returned.

A lookup is combinational. The fetch stage presents an address and receives both component predictions, the selector choice and the final prediction in the same cycle. When the branch resolves, the pipeline presents an update. The update carries the address, the real outcome and the two component predictions captured at lookup time. Both component tables are trained on every update. The selector moves only when the two captured predictions disagree, and it always moves toward the component that was right. The global history shifts in the outcome.

Top module: `duo_pred_chooser`

## Requirements
- R1: After reset every bimodal, correlating and selector counter holds 01 and the global history is all zeros. Every lookup then returns lk_pred_bim=0, lk_pred_glob=0, lk_use_glob=0 and lk_taken=0.
- R2: The lookup outputs are combinational in lk_pc and the current state. lk_taken equals lk_pred_glob when lk_use_glob is 1 and equals lk_pred_bim otherwise.
- R3: lk_pred_bim is the MSB of the bimodal counter at lk_pc[BIM_IDX_W-1:0]. An update increments the counter at upd_pc[BIM_IDX_W-1:0] (saturating at 11) when upd_taken=1 and decrements it (saturating at 00) otherwise. The change is visible from the next cycle.
- R4: lk_pred_glob is the MSB of the correlating counter at index {history, lk_pc[GPC_W-1:0]}, with the history in the upper bits. An update trains the counter at {history, upd_pc[GPC_W-1:0]} in the same saturating way. The history used is the one in force during the update cycle, before that update shifts it.
- R5: Each update shifts the global history left by one and places upd_taken in bit 0.
- R6: When upd_pred_bim equals upd_pred_glob, the selector entry is left unchanged, whatever the outcome.
- R7: When the two captured predictions differ, the selector entry at upd_pc[SEL_IDX_W-1:0] moves one step toward the component that matched upd_taken. A step toward the correlating component is +1, saturating at 11. A step toward the bimodal component is -1, saturating at 00. lk_use_glob is the entry's MSB, so from reset a single disagreement won by the correlating component switches the choice.
- R8: The selector adjustment uses only the captured upd_pred_bim and upd_pred_glob, not the present contents of the component tables.
- R9: While upd_valid is 0, no counter and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Branch address being looked up |
| lk_taken | output | 1 | Final predicted direction |
| lk_pred_bim | output | 1 | Bimodal component prediction |
| lk_pred_glob | output | 1 | Correlating component prediction |
| lk_use_glob | output | 1 | 1 when the selector favours the correlating component |
| upd_valid | input | 1 | Resolved branch update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_pred_bim | input | 1 | Bimodal prediction captured at lookup |
| upd_pred_glob | input | 1 | Correlating prediction captured at lookup |

## Verification
Directed sequences on a single address drive the selector through disagreements won by each component and through agreements that are both right or both wrong. These separate a selector that moves on any misprediction from one that moves only on disagreement. Captured predictions that contradict the tables show whether the selector reads the update port or the tables. Idle stretches with noisy update fields show whether state leaks in without the strobe. Long random runs over a small set of aliasing addresses, with outcomes both tied to and independent of the address, push the counters to saturation at both ends. They also vary the history so that the correlating index and its pre-shift timing are distinguished.

// File: rtl/duo_pred_pkg.sv
package duo_pred_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_LOW = 2'b01;

  // Saturating 2-bit step: up moves toward 11, otherwise toward 00.
  function automatic ctr2_t ctr_step(ctr2_t cur, logic up);
    ctr2_t nxt;
    if (up) nxt = (cur == 2'b11) ? cur : cur + 2'b01;
    else    nxt = (cur == 2'b00) ? cur : cur - 2'b01;
    return nxt;
  endfunction

  // Decision bit of a counter.
  function automatic logic ctr_says(ctr2_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/duo_ctr_table.sv
module duo_ctr_table
  import duo_pred_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter ctr2_t RST_VAL = CTR_WEAK_LOW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_q,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up,
  output ctr2_t            wr_cur
);

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[e] <= RST_VAL;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        mem[e] <= ctr_step(mem[e], wr_up);
      end
    end
  end

  assign rd_q   = mem[rd_idx];
  assign wr_cur = mem[wr_idx];

endmodule

// File: rtl/duo_ghist_reg.sv
module duo_ghist_reg #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_q
);

  logic [HIST_W:0] widened;

  assign widened = {hist_q, bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= widened[HIST_W-1:0];
    end
  end

endmodule

// File: rtl/duo_pred_chooser.sv
module duo_pred_chooser
  import duo_pred_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int BIM_IDX_W = 4,
  parameter int SEL_IDX_W = 4,
  parameter int HIST_W    = 2,
  parameter int GPC_W     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_pred_bim,
  output logic            lk_pred_glob,
  output logic            lk_use_glob,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_pred_bim,
  input  logic            upd_pred_glob
);

  localparam int GLB_IDX_W = HIST_W + GPC_W;

  // Internal events, named for the checker.
  logic [HIST_W-1:0]    hist_q;
  logic [GLB_IDX_W-1:0] glb_lk_idx;
  logic [GLB_IDX_W-1:0] glb_upd_idx;
  ctr2_t                bim_rd, glb_rd, sel_rd;
  ctr2_t                bim_at_upd, glb_at_upd, sel_at_upd;
  logic                 bim_ok, glb_ok;
  logic                 sel_move;
  logic                 sel_toward_glob;
  logic                 unused_pc_bits;

  assign unused_pc_bits = ^{lk_pc, upd_pc};

  assign glb_lk_idx  = {hist_q, lk_pc[GPC_W-1:0]};
  assign glb_upd_idx = {hist_q, upd_pc[GPC_W-1:0]};

  // Selector decision from captured component predictions only.
  assign bim_ok          = (upd_pred_bim  == upd_taken);
  assign glb_ok          = (upd_pred_glob == upd_taken);
  assign sel_move        = upd_valid && (bim_ok != glb_ok);
  assign sel_toward_glob = glb_ok;

  duo_ctr_table #(.IDX_W(BIM_IDX_W), .RST_VAL(CTR_WEAK_LOW)) u_bim (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (lk_pc[BIM_IDX_W-1:0]),
    .rd_q   (bim_rd),
    .wr_en  (upd_valid),
    .wr_idx (upd_pc[BIM_IDX_W-1:0]),
    .wr_up  (upd_taken),
    .wr_cur (bim_at_upd)
  );

  duo_ctr_table #(.IDX_W(GLB_IDX_W), .RST_VAL(CTR_WEAK_LOW)) u_glb (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (glb_lk_idx),
    .rd_q   (glb_rd),
    .wr_en  (upd_valid),
    .wr_idx (glb_upd_idx),
    .wr_up  (upd_taken),
    .wr_cur (glb_at_upd)
  );

  duo_ctr_table #(.IDX_W(SEL_IDX_W), .RST_VAL(CTR_WEAK_LOW)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (lk_pc[SEL_IDX_W-1:0]),
    .rd_q   (sel_rd),
    .wr_en  (sel_move),
    .wr_idx (upd_pc[SEL_IDX_W-1:0]),
    .wr_up  (sel_toward_glob),
    .wr_cur (sel_at_upd)
  );

  duo_ghist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_valid),
    .bit_in   (upd_taken),
    .hist_q   (hist_q)
  );

  assign lk_pred_bim  = ctr_says(bim_rd);
  assign lk_pred_glob = ctr_says(glb_rd);
  assign lk_use_glob  = ctr_says(sel_rd);
  assign lk_taken     = lk_use_glob ? lk_pred_glob : lk_pred_bim;

endmodule

// File: rtl/duo_pred_chooser_chk.sv
module duo_pred_chooser_chk #(
  parameter int PC_W   = 12,
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_valid,
  input logic [PC_W-1:0]   upd_pc,
  input logic              upd_taken,
  input logic              upd_pred_bim,
  input logic              upd_pred_glob,
  input logic [HIST_W-1:0] hist_q,
  input logic [1:0]        bim_at_upd,
  input logic [1:0]        sel_at_upd
);

  // R5: newest outcome lands in history bit 0.
  p_hist_newest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (hist_q[0] == $past(upd_taken)));

  // R9: no update, no history movement.
  p_idle_hist_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hist_q));

  // R6: agreeing captured predictions leave the selector alone.
  p_agree_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_pred_bim == upd_pred_glob))
    |=> ($stable(upd_pc) -> $stable(sel_at_upd)));

  // R7: correlating side wins, selector climbs by one unless saturated.
  p_sel_climb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_pred_glob == upd_taken) && (upd_pred_bim != upd_taken)
     && (sel_at_upd != 2'b11))
    |=> ($stable(upd_pc) -> (sel_at_upd == $past(sel_at_upd) + 2'b01)));

  // R7: bimodal side wins, selector drops by one unless saturated.
  p_sel_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_pred_bim == upd_taken) && (upd_pred_glob != upd_taken)
     && (sel_at_upd != 2'b00))
    |=> ($stable(upd_pc) -> (sel_at_upd == $past(sel_at_upd) - 2'b01)));

  // R3: taken outcome saturates at 11.
  p_bim_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && (bim_at_upd == 2'b11))
    |=> ($stable(upd_pc) -> (bim_at_upd == 2'b11)));

endmodule

bind duo_pred_chooser duo_pred_chooser_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .upd_valid     (upd_valid),
  .upd_pc        (upd_pc),
  .upd_taken     (upd_taken),
  .upd_pred_bim  (upd_pred_bim),
  .upd_pred_glob (upd_pred_glob),
  .hist_q        (hist_q),
  .bim_at_upd    (bim_at_upd),
  .sel_at_upd    (sel_at_upd)
);

// File: tb/duo_pred_chooser_test.sv
`timescale 1ns/1ps
module duo_pred_chooser_test;

  localparam int PC_W = 12;
  localparam int BIM_N = 16;
  localparam int SEL_N = 16;
  localparam int HIST_N = 4;
  localparam int GPC_N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic lk_taken, lk_pred_bim, lk_pred_glob, lk_use_glob;
  logic upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic upd_taken = 1'b0, upd_pred_bim = 1'b0, upd_pred_glob = 1'b0;

  always #10 clk = ~clk;

  duo_pred_chooser uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_pred_bim(lk_pred_bim), .lk_pred_glob(lk_pred_glob),
    .lk_use_glob(lk_use_glob), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_pred_bim(upd_pred_bim),
    .upd_pred_glob(upd_pred_glob)
  );

  // Behavioural reference state.
  int m_bim [BIM_N];
  int m_glb [HIST_N*GPC_N];
  int m_sel [SEL_N];
  int m_hist;
  int vectors = 0;
  int fails = 0;

  function automatic int bump(int c, bit up);
    if (up) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  function automatic bit exp_bim(int pc);  return m_bim[pc % BIM_N] >= 2; endfunction
  function automatic bit exp_glob(int pc); return m_glb[m_hist*GPC_N + pc % GPC_N] >= 2; endfunction
  function automatic bit exp_sel(int pc);  return m_sel[pc % SEL_N] >= 2; endfunction

  task automatic model_reset();
    foreach (m_bim[i]) m_bim[i] = 1;
    foreach (m_glb[i]) m_glb[i] = 1;
    foreach (m_sel[i]) m_sel[i] = 1;
    m_hist = 0;
  endtask

  task automatic model_update(int pc, bit tk, bit pb, bit pg);
    int gi;
    gi = m_hist*GPC_N + pc % GPC_N;
    m_bim[pc % BIM_N] = bump(m_bim[pc % BIM_N], tk);
    m_glb[gi] = bump(m_glb[gi], tk);
    if (pb != pg) m_sel[pc % SEL_N] = bump(m_sel[pc % SEL_N], pg == tk);
    m_hist = ((m_hist << 1) | int'(tk)) % HIST_N;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, compare every output, then advance the model.
  task automatic cyc(int lpc, bit uv, int upc, bit tk, bit pb, bit pg, string tag);
    bit eb, eg, es;
    @(negedge clk);
    lk_pc = PC_W'(lpc); upd_valid = uv; upd_pc = PC_W'(upc);
    upd_taken = tk; upd_pred_bim = pb; upd_pred_glob = pg;
    #1;
    eb = exp_bim(lpc); eg = exp_glob(lpc); es = exp_sel(lpc);
    chk({tag, " R3 bimodal"}, lk_pred_bim, eb);
    chk({tag, " R4 correlating"}, lk_pred_glob, eg);
    chk({tag, " R7 selector"}, lk_use_glob, es);
    chk({tag, " R2 final"}, lk_taken, es ? eg : eb);
    @(posedge clk);
    if (uv) model_update(upc, tk, pb, pg);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int pcs [6];
    pcs = '{5, 21, 37, 100, 6, 2047};
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state seen through lookups at several addresses.
    for (int i = 0; i < 16; i++) cyc(i * 37, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R1");

    // R7: one disagreement won by the correlating side switches from reset.
    cyc(5, 1'b1, 5, 1'b1, 1'b0, 1'b1, "R7");
    cyc(5, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R7");
    // R6: both wrong, then both right: selector must hold.
    cyc(5, 1'b1, 5, 1'b0, 1'b1, 1'b1, "R6");
    cyc(5, 1'b1, 5, 1'b1, 1'b1, 1'b1, "R6");
    cyc(5, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R6");
    // R7: climb to saturation, then two bimodal wins to switch back.
    for (int i = 0; i < 4; i++) cyc(5, 1'b1, 5, 1'b0, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 3; i++) cyc(5, 1'b1, 5, 1'b1, 1'b1, 1'b0, "R7");
    cyc(5, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R7");
    // R8: captured predictions contradict the tables; selector follows them.
    for (int i = 0; i < 4; i++) cyc(9, 1'b1, 9, 1'b1, 1'b0, 1'b1, "R8");
    cyc(9, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R8");
    // R3: drive a counter to both saturation ends.
    for (int i = 0; i < 5; i++) cyc(3, 1'b1, 3, 1'b1, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 5; i++) cyc(3, 1'b1, 3, 1'b0, 1'b0, 1'b0, "R3");
    // R4/R5: repeating outcome pattern on one address trains history-indexed entries.
    for (int i = 0; i < 24; i++) cyc(2, 1'b1, 2, (i % 3) != 0, 1'b0, 1'b1, "R4/R5");

    // R9: strobe low with busy update fields; nothing may change.
    for (int i = 0; i < 40; i++)
      cyc(pcs[i % 6], 1'b0, pcs[(i + 1) % 6], 1'($urandom), 1'($urandom),
          1'($urandom), "R9");

    // Random mix over aliasing addresses.
    for (int i = 0; i < 3000; i++) begin
      int lp, up;
      bit tk, pb, pg;
      lp = pcs[$urandom % 6];
      up = pcs[$urandom % 6];
      tk = ($urandom % 4 == 0) ? 1'($urandom) : bit'((up / 5) % 2);
      if ($urandom % 2 == 0) begin
        pb = exp_bim(up); pg = exp_glob(up);
      end else begin
        pb = 1'($urandom); pg = 1'($urandom);
      end
      cyc(lp, ($urandom % 5) != 0, up, tk, pb, pg, "R2/R6/R7");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule